// File: doc/BRIEF.md
# Branch Trace Record Store Controller

This block receives branch events from a pipeline model. Each event carries a source address, a target address and a flag. A three-bit control register selects what happens to each event. It can be dropped. It can be forwarded as a trace message on an output bus. It can be logged as a fixed three-word record through a simple memory write port. No event is ever sent to the bus and logged at the same time.

Four buffer registers describe the log region: base, current index, absolute maximum and interrupt threshold. Each record writes three words at consecutive addresses starting at the index: source, then target, then a flags word. After the third word the index moves forward by one record.

The interrupt-enable flag chooses how the log behaves as it fills:
- When the flag is clear, the log is circular and the index returns to the base.
- When the flag is set, the block raises an interrupt at the threshold. Once the index reaches the absolute maximum, further records are dropped.

An event that arrives while a record is still being written waits in a one-entry skid register. If that register is already full, a sticky overflow status is raised.

Top module: `branch_log_ctrl`

## Requirements
- R1: When control bit 0 (trace enable) is 0, no trace message is produced and no memory write occurs, whatever control bits 1 and 2 hold.
- R2: With control bits {2,1,0} = x01, each accepted branch produces `msg_valid` in the following cycle, carrying the same source, target and flag, and the memory port stays idle.
- R3: With control bits 1 and 0 set, each branch is logged with no message. The record is written on three consecutive cycles, beginning the cycle after the event is sampled:
  - source at address index,
  - target at index+4,
  - flags word (flag in bit 0, zeros elsewhere) at index+8.
  The index then rises by 12.
- R4: With control bit 2 clear (circular log), a record completion whose advanced index would be greater than or equal to the absolute maximum sets the index to the base instead.
- R5: With control bit 2 set, `irq_o` rises in the cycle after the record completion that leaves the index at or above the threshold. It stays high until a configuration write to register address 5.
- R6: With control bits 2, 1 and 0 set and the index at or above the absolute maximum, a branch is dropped: no write occurs and the index does not change.
- R7: A write to the base register (address 1) forces the two low address bits to zero. Register addresses are: 0 control, 1 base, 2 index, 3 absolute maximum, 4 threshold, 5 interrupt clear.
- R8: A branch that arrives while a record is being written is held and logged, in arrival order, after the current record.
- R9: A branch that arrives while a record is in progress and the holding register is full is discarded, and `ovf_o` becomes 1 and stays 1.
- R10: After reset, all registers are zero and `msg_valid`, `mem_we`, `irq_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| br_valid | input | 1 | Branch event valid |
| br_src | input | 32 | Branch source address |
| br_dst | input | 32 | Branch target address |
| br_flag | input | 1 | Branch flag |
| msg_valid | output | 1 | Trace message valid |
| msg_src | output | 32 | Trace message source address |
| msg_dst | output | 32 | Trace message target address |
| msg_flag | output | 1 | Trace message flag |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| idx_o | output | 32 | Current buffer index |
| irq_o | output | 1 | Buffer nearly-full interrupt |
| ovf_o | output | 1 | Sticky event overflow status |

## Verification
Two functions can fall into the same cycle:
- A new branch can be sampled during the final word of a record. In that cycle the running record also advances the index, wraps it and may raise the interrupt.
- A third branch can reach a full holding register while the writer is still busy.

The bench provokes both by driving branches on consecutive cycles. A scoreboard queue then judges that every expected word appears in order at the right address, and that the extra branch produces no write. The bench also checks the index after the wrap and the sticky overflow bit.

// File: rtl/btl_pkg.sv
package btl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_W0,
      ST_W1,
      ST_W2
   } wr_state_t;

   localparam logic [2:0] CFG_CTRL   = 3'd0;
   localparam logic [2:0] CFG_BASE   = 3'd1;
   localparam logic [2:0] CFG_INDEX  = 3'd2;
   localparam logic [2:0] CFG_LIMIT  = 3'd3;
   localparam logic [2:0] CFG_THRESH = 3'd4;
   localparam logic [2:0] CFG_IRQCLR = 3'd5;

   typedef struct packed {
      logic irq_en;
      logic store_en;
      logic trace_en;
   } ctrl_t;

endpackage

// File: rtl/btl_cfg_regs.sv
module btl_cfg_regs
   import btl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output ctrl_t             ctrl,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] limit,
   output logic [ADDR_W-1:0] thresh,
   output logic              idx_wr,
   output logic              irq_clr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         base   <= '0;
         limit  <= '0;
         thresh <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            CFG_CTRL:   ctrl   <= ctrl_t'(cfg_wdata[2:0]);
            CFG_BASE:   base   <= {cfg_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            CFG_LIMIT:  limit  <= cfg_wdata;
            CFG_THRESH: thresh <= cfg_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      idx_wr  = cfg_we && (cfg_addr == CFG_INDEX);
      irq_clr = cfg_we && (cfg_addr == CFG_IRQCLR);
   end

endmodule

// File: rtl/btl_msg_path.sv
module btl_msg_path #(
   parameter int ADDR_W  = 32,
   parameter int FLAG_W  = 1,
   parameter bit MSG_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_mode,
   input  logic              ev_valid,
   input  logic [ADDR_W-1:0] ev_src,
   input  logic [ADDR_W-1:0] ev_dst,
   input  logic [FLAG_W-1:0] ev_flag,
   output logic              msg_valid,
   output logic [ADDR_W-1:0] msg_src,
   output logic [ADDR_W-1:0] msg_dst,
   output logic [FLAG_W-1:0] msg_flag
);

   generate
      if (MSG_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               msg_valid <= 1'b0;
               msg_src   <= '0;
               msg_dst   <= '0;
               msg_flag  <= '0;
            end else begin
               msg_valid <= ev_valid && bus_mode;
               if (ev_valid && bus_mode) begin
                  msg_src  <= ev_src;
                  msg_dst  <= ev_dst;
                  msg_flag <= ev_flag;
               end
            end
         end

         // R2: a bus-mode branch shows up as a message one cycle later
         p_bus_msg_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_valid && bus_mode) |=> (msg_valid && msg_src == $past(ev_src)))
            else $error("p_bus_msg_r2");
      end else begin : g_comb
         always_comb begin
            msg_valid = ev_valid && bus_mode;
            msg_src   = ev_src;
            msg_dst   = ev_dst;
            msg_flag  = ev_flag;
         end
      end
   endgenerate

endmodule

// File: rtl/btl_rec_writer.sv
module btl_rec_writer
   import btl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int FLAG_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trace_en,
   input  logic              store_en,
   input  logic              irq_en,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] limit,
   input  logic [ADDR_W-1:0] thresh,
   input  logic              idx_wr,
   input  logic [ADDR_W-1:0] idx_wdata,
   input  logic              irq_clr,
   input  logic              ev_valid,
   input  logic [ADDR_W-1:0] ev_src,
   input  logic [ADDR_W-1:0] ev_dst,
   input  logic [FLAG_W-1:0] ev_flag,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] idx_o,
   output logic              irq_o,
   output logic              ovf_o
);

   localparam int WORD_BYTES = ADDR_W / 8;
   localparam int REC_BYTES  = 3 * WORD_BYTES;

   typedef struct packed {
      logic [ADDR_W-1:0] src;
      logic [ADDR_W-1:0] dst;
      logic [FLAG_W-1:0] flag;
   } rec_t;

   wr_state_t         state_q;
   rec_t              hold_q, skid_q, in_rec, start_rec;
   logic              skid_v;
   logic [ADDR_W-1:0] idx_q, idx_step, idx_adv;
   logic              store_mode, blocked, idle, take_skid, start, push, load_skid;

   always_comb begin
      store_mode = trace_en && store_en;
      blocked    = irq_en && (idx_q >= limit);
      idle       = (state_q == ST_IDLE);
      in_rec     = '{src: ev_src, dst: ev_dst, flag: ev_flag};
      take_skid  = idle && skid_v;
      start_rec  = take_skid ? skid_q : in_rec;
      start      = idle && (skid_v || ev_valid) && store_mode && !blocked;
      push       = ev_valid && store_mode && (!idle || skid_v);
      load_skid  = push && (!skid_v || take_skid);
      idx_step   = idx_q + ADDR_W'(REC_BYTES);
      idx_adv    = (!irq_en && idx_step >= limit) ? base : idx_step;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
         skid_q  <= '0;
         skid_v  <= 1'b0;
         idx_q   <= '0;
         irq_o   <= 1'b0;
         ovf_o   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               hold_q  <= start_rec;
               state_q <= ST_W0;
            end
            ST_W0:   state_q <= ST_W1;
            ST_W1:   state_q <= ST_W2;
            default: state_q <= ST_IDLE;
         endcase

         if (load_skid) begin
            skid_q <= in_rec;
            skid_v <= 1'b1;
         end else if (take_skid) begin
            skid_v <= 1'b0;
         end
         if (push && !load_skid) ovf_o <= 1'b1;

         if (idx_wr)                  idx_q <= idx_wdata;
         else if (state_q == ST_W2)   idx_q <= idx_adv;

         if (state_q == ST_W2 && irq_en && idx_step >= thresh) irq_o <= 1'b1;
         else if (irq_clr)                                     irq_o <= 1'b0;
      end
   end

   always_comb begin
      mem_we    = !idle;
      mem_addr  = idx_q;
      mem_wdata = hold_q.src;
      case (state_q)
         ST_W1: begin
            mem_addr  = idx_q + ADDR_W'(WORD_BYTES);
            mem_wdata = hold_q.dst;
         end
         ST_W2: begin
            mem_addr  = idx_q + ADDR_W'(2 * WORD_BYTES);
            mem_wdata = {{(ADDR_W-FLAG_W){1'b0}}, hold_q.flag};
         end
         default: ;
      endcase
   end

   assign idx_o = idx_q;

   // R5: the interrupt holds until a clear write
   p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr) |=> irq_o) else $error("p_irq_hold_r5");

   // R9: overflow status is sticky
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o) else $error("p_ovf_sticky_r9");

   // R6: a full log in interrupt mode starts no write
   p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && store_mode && irq_en && idx_q >= limit && !idx_wr) |=> !mem_we)
      else $error("p_drop_full_r6");

   // R4: circular log returns to base
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_W2 && !irq_en && !idx_wr && idx_step >= limit) |=> (idx_o == $past(base)))
      else $error("p_wrap_r4");

   // R3: the three words of a record are written back to back
   p_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == idx_q) |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)))
      else $error("p_burst_r3");

endmodule

// File: rtl/branch_log_ctrl.sv
module branch_log_ctrl
   import btl_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int FLAG_W  = 1,
   parameter bit MSG_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              br_valid,
   input  logic [ADDR_W-1:0] br_src,
   input  logic [ADDR_W-1:0] br_dst,
   input  logic [FLAG_W-1:0] br_flag,
   output logic              msg_valid,
   output logic [ADDR_W-1:0] msg_src,
   output logic [ADDR_W-1:0] msg_dst,
   output logic [FLAG_W-1:0] msg_flag,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] idx_o,
   output logic              irq_o,
   output logic              ovf_o
);

   localparam int ALIGN_BITS = $clog2(ADDR_W / 8);

   initial begin
      if (ADDR_W < 16 || (ADDR_W % 8) != 0) $error("ADDR_W must be a byte multiple of at least 16");
      if (FLAG_W < 1 || FLAG_W >= ADDR_W)   $error("FLAG_W must lie in 1..ADDR_W-1");
   end

   ctrl_t             ctrl;
   logic [ADDR_W-1:0] base, limit, thresh;
   logic              idx_wr, irq_clr, bus_mode;

   btl_cfg_regs #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ctrl(ctrl), .base(base), .limit(limit),
      .thresh(thresh), .idx_wr(idx_wr), .irq_clr(irq_clr));

   assign bus_mode = ctrl.trace_en && !ctrl.store_en;

   btl_msg_path #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .MSG_REG(MSG_REG)) u_msg (
      .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .ev_valid(br_valid),
      .ev_src(br_src), .ev_dst(br_dst), .ev_flag(br_flag),
      .msg_valid(msg_valid), .msg_src(msg_src), .msg_dst(msg_dst), .msg_flag(msg_flag));

   btl_rec_writer #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .trace_en(ctrl.trace_en), .store_en(ctrl.store_en),
      .irq_en(ctrl.irq_en), .base(base), .limit(limit), .thresh(thresh),
      .idx_wr(idx_wr), .idx_wdata(cfg_wdata), .irq_clr(irq_clr),
      .ev_valid(br_valid), .ev_src(br_src), .ev_dst(br_dst), .ev_flag(br_flag),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .idx_o(idx_o), .irq_o(irq_o), .ovf_o(ovf_o));

   // R3: a branch is never both forwarded and logged in one cycle
   p_one_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && msg_valid)) else $error("p_one_route_r3");

   // R1: tracing off produces no message
   p_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.trace_en |=> !msg_valid) else $error("p_silent_r1");

endmodule

// File: tb/test_branch_log_ctrl.sv
module test_branch_log_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        br_valid = 1'b0;
   logic [31:0] br_src = '0, br_dst = '0;
   logic [0:0]  br_flag = '0;
   logic        msg_valid, mem_we, irq_o, ovf_o;
   logic [31:0] msg_src, msg_dst, mem_addr, mem_wdata, idx_o;
   logic [0:0]  msg_flag;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R10";

   logic [63:0] exp_wr[$];
   logic [64:0] exp_msg[$];
   logic [31:0] m_base, m_lim, m_idx;
   logic        m_irqmode;

   always #5 clk = ~clk;

   branch_log_ctrl i_branch_log_ctrl (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (exp_wr.size() == 0) check({cur_tag, " unexpected write"}, mem_addr, 32'hxxxx_xxxx);
            else begin
               logic [63:0] e;
               e = exp_wr.pop_front();
               check({cur_tag, " R3 write addr"}, mem_addr, e[63:32]);
               check({cur_tag, " R3 write data"}, mem_wdata, e[31:0]);
            end
         end
         if (msg_valid) begin
            if (exp_msg.size() == 0) check({cur_tag, " unexpected message"}, msg_src, 32'hxxxx_xxxx);
            else begin
               logic [64:0] m;
               m = exp_msg.pop_front();
               check("R2 msg src", msg_src, m[64:33]);
               check("R2 msg dst", msg_dst, m[32:1]);
               check("R2 msg flag", {31'b0, msg_flag}, {31'b0, m[0]});
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push_rec(input logic [31:0] s, input logic [31:0] d, input logic f);
      logic [31:0] step;
      exp_wr.push_back({m_idx, s});
      exp_wr.push_back({m_idx + 32'd4, d});
      exp_wr.push_back({m_idx + 32'd8, {31'b0, f}});
      step = m_idx + 32'd12;
      m_idx = (!m_irqmode && step >= m_lim) ? m_base : step;
   endtask

   task automatic drive(input logic [31:0] s, input logic [31:0] d, input logic f);
      br_valid = 1'b1; br_src = s; br_dst = d; br_flag = f;
      @(negedge clk);
      br_valid = 1'b0;
   endtask

   task automatic send(input logic [31:0] s, input logic [31:0] d, input logic f);
      @(negedge clk);
      drive(s, d, f);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_irqmode = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R10 reset state
      check("R10 idx", idx_o, 32'h0);
      check("R10 irq", {31'b0, irq_o}, 32'h0);
      check("R10 ovf", {31'b0, ovf_o}, 32'h0);
      check("R10 mem_we", {31'b0, mem_we}, 32'h0);
      check("R10 msg_valid", {31'b0, msg_valid}, 32'h0);

      // R1 tracing off, other bits set
      cur_tag = "R1";
      cfg(3'd0, 32'h6);
      send(32'hA0, 32'hB0, 1'b1);
      send(32'hA4, 32'hB4, 1'b0);
      cfg(3'd0, 32'h2);
      send(32'hA8, 32'hB8, 1'b1);
      idle(6);
      check("R1 index untouched", idx_o, 32'h0);

      // R2 bus mode, with and without bit 2
      cur_tag = "R2";
      cfg(3'd0, 32'h1);
      exp_msg.push_back({32'h1111_0000, 32'h2222_0000, 1'b1});
      send(32'h1111_0000, 32'h2222_0000, 1'b1);
      cfg(3'd0, 32'h5);
      exp_msg.push_back({32'h3333_0000, 32'h4444_0000, 1'b0});
      send(32'h3333_0000, 32'h4444_0000, 1'b0);
      idle(4);
      check("R2 messages delivered", exp_msg.size(), 0);
      check("R2 no index move", idx_o, 32'h0);

      // R3 R4 R7 circular log
      cur_tag = "R3";
      cfg(3'd1, 32'h0000_1003);
      cfg(3'd2, 32'h0000_1000);
      cfg(3'd3, 32'h0000_1024);
      m_base = 32'h1000; m_lim = 32'h1024; m_idx = 32'h1000;
      cfg(3'd0, 32'h3);
      push_rec(32'hC000_0001, 32'hD000_0001, 1'b1);
      send(32'hC000_0001, 32'hD000_0001, 1'b1);
      idle(4);
      check("R3 index after record", idx_o, 32'h100C);
      push_rec(32'hC000_0002, 32'hD000_0002, 1'b0);
      send(32'hC000_0002, 32'hD000_0002, 1'b0);
      idle(4);
      check("R3 index second", idx_o, 32'h1018);
      cur_tag = "R4";
      push_rec(32'hC000_0003, 32'hD000_0003, 1'b1);
      send(32'hC000_0003, 32'hD000_0003, 1'b1);
      idle(4);
      check("R4 R7 wrap to aligned base", idx_o, 32'h1000);

      // R8 R9 back-to-back branches
      cur_tag = "R8";
      push_rec(32'hE000_0001, 32'hF000_0001, 1'b0);
      push_rec(32'hE000_0002, 32'hF000_0002, 1'b1);
      @(negedge clk);
      drive(32'hE000_0001, 32'hF000_0001, 1'b0);
      drive(32'hE000_0002, 32'hF000_0002, 1'b1);
      drive(32'hE000_0003, 32'hF000_0003, 1'b1);
      idle(12);
      check("R8 held record written", exp_wr.size(), 0);
      check("R8 index after two", idx_o, 32'h1018);
      check("R9 overflow set", {31'b0, ovf_o}, 32'h1);

      // R5 R6 interrupt mode
      cur_tag = "R5";
      cfg(3'd1, 32'h0000_2000);
      cfg(3'd2, 32'h0000_2000);
      cfg(3'd4, 32'h0000_2018);
      cfg(3'd3, 32'h0000_2024);
      m_base = 32'h2000; m_lim = 32'h2024; m_idx = 32'h2000; m_irqmode = 1'b1;
      cfg(3'd0, 32'h7);
      push_rec(32'h5000_0001, 32'h6000_0001, 1'b1);
      send(32'h5000_0001, 32'h6000_0001, 1'b1);
      idle(4);
      check("R5 below threshold idx", idx_o, 32'h200C);
      check("R5 no irq below threshold", {31'b0, irq_o}, 32'h0);
      push_rec(32'h5000_0002, 32'h6000_0002, 1'b0);
      send(32'h5000_0002, 32'h6000_0002, 1'b0);
      idle(2);
      check("R5 irq not early", {31'b0, irq_o}, 32'h0);
      idle(1);
      check("R5 irq at threshold", {31'b0, irq_o}, 32'h1);
      check("R5 idx at threshold", idx_o, 32'h2018);
      push_rec(32'h5000_0003, 32'h6000_0003, 1'b1);
      send(32'h5000_0003, 32'h6000_0003, 1'b1);
      idle(4);
      check("R5 no wrap in irq mode", idx_o, 32'h2024);
      check("R5 irq held", {31'b0, irq_o}, 32'h1);
      cur_tag = "R6";
      send(32'h5000_0004, 32'h6000_0004, 1'b0);
      idle(6);
      check("R6 index frozen when full", idx_o, 32'h2024);
      check("R6 no pending writes", exp_wr.size(), 0);
      cur_tag = "R5";
      cfg(3'd5, 32'h0);
      idle(1);
      check("R5 irq cleared", {31'b0, irq_o}, 32'h0);
      check("R9 overflow still set", {31'b0, ovf_o}, 32'h1);

      idle(2);
      check("R3 write queue drained", exp_wr.size(), 0);
      check("R2 message queue drained", exp_msg.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule